// File: doc/BRIEF.md
# System Clock Source Switcher

This block picks the system clock from five candidate sources and divides it by a programmable amount. Each source is modelled as a one-cycle enable pulse in the single clock domain of the block. The selected pulse train is counted, and the block emits a clock-enable strobe once per `N + 1` selected pulses. A real glitch-free mux across asynchronous clocks is not modelled.

Software writes a configuration byte that holds a 3-bit source code and a 4-bit divide value. That write only has an effect after a three-byte key has been written to a protection address. When a new source is requested, the block checks the stable flag of the target. A stable target is committed. An unstable or reserved target leaves the current source in place and raises a sticky failure flag, which software clears by writing 1. After reset the source code comes from a boot configuration input.

Top module: `sysclk_switch`

## Requirements
- R1: After reset, `sel_code` is 3'b111 when `boot_hi` is 1 and 3'b000 when it is 0. At the same time `switch_fail` is 0, `unlocked` is 0 and `div_active` is 0.
- R2: Source codes map to `src_pulse`/`src_stable` bits as follows: 3'b000 to bit 0, 3'b001 to bit 1, 3'b010 to bit 2, 3'b011 to bit 3 and 3'b111 to bit 4. Codes 3'b100, 3'b101 and 3'b110 are reserved. `sel_code` only ever holds a legal code.
- R3: `clk_en` pulses one cycle after the selected source pulse that completes a count of `div_active + 1` pulses. It is low at every other time.
- R4: An accepted configuration write stores its divide field, bits [7:4], as pending. `div_active` takes the pending value only on a cycle where `clk_en` fires, and never at any other time.
- R5: Writing the bytes 8'h59, 8'h16 and 8'h88, in that order, to address 2'd0 sets `unlocked`. Any other byte at any step returns the key sequence to its first step.
- R6: While unlocked, any write to address 2'd0 clears `unlocked`. A write to the configuration address 2'd1 while locked leaves `sel_code`, the pending divide value and `switch_fail` unchanged.
- R7: An accepted configuration write whose code (bits [2:0]) is legal and whose source reports stable sets `sel_code` to that code and clears `switch_fail`.
- R8: An accepted configuration write with an unstable or reserved target sets `switch_fail` and keeps the previous `sel_code`.
- R9: A write to address 2'd2 with data bit 0 set clears `switch_fail`. The same write with bit 0 clear has no effect.
- R10: A committed switch restarts the divide count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_hi | input | 1 | Boot default source: 1 selects code 111, 0 selects code 000 |
| src_pulse | input | 5 | Per-source enable pulses |
| src_stable | input | 5 | Per-source stable flags |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 key, 1 configuration, 2 failure clear |
| wr_data | input | 8 | Write byte |
| sel_code | output | 3 | Current source code |
| div_active | output | 4 | Divide value in use |
| unlocked | output | 1 | Configuration writes accepted |
| switch_fail | output | 1 | Sticky failed-switch flag |
| clk_en | output | 1 | Divided clock-enable strobe |

## Verification
A corrupted key state shows up on `unlocked` on the edge after the offending byte. It also shows a few cycles later, when a configuration write is wrongly taken or wrongly dropped and `sel_code` or `switch_fail` differs from the model. A wrong divide count or a stale divide value shifts `clk_en` away from the modelled strobe within one divide period, at most 16 selected pulses. A wrong decode of the source code shows as `clk_en` following another source's pulse pattern on the first selected pulse.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
    localparam int NSRC   = 5;
    localparam int SEL_W  = 3;
    localparam int DIV_W  = 4;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int SEL_LSB = 0;
    localparam int DIV_LSB = BYTE_W - DIV_W;

    localparam logic [ADDR_W-1:0] A_KEY  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CLR  = 2'd2;

    localparam logic [BYTE_W-1:0] KEY0 = 8'h59;
    localparam logic [BYTE_W-1:0] KEY1 = 8'h16;
    localparam logic [BYTE_W-1:0] KEY2 = 8'h88;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_ONE  = 2'd1,
        LK_TWO  = 2'd2,
        LK_OPEN = 2'd3
    } lock_e;

    typedef struct packed {
        logic             ok;
        logic [IDX_W-1:0] idx;
    } src_map_t;

    // Source code to source index; reserved codes give ok = 0.
    function automatic src_map_t map_code(input logic [SEL_W-1:0] code);
        src_map_t m;
        m.ok  = 1'b1;
        m.idx = '0;
        case (code)
            3'b000:  m.idx = IDX_W'(0);
            3'b001:  m.idx = IDX_W'(1);
            3'b010:  m.idx = IDX_W'(2);
            3'b011:  m.idx = IDX_W'(3);
            3'b111:  m.idx = IDX_W'(4);
            default: m.ok  = 1'b0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/sysclk_unlock.sv
module sysclk_unlock
    import sysclk_pkg::*;
#(
    parameter int                BW = BYTE_W,
    parameter logic [BW-1:0]     K0 = KEY0,
    parameter logic [BW-1:0]     K1 = KEY1,
    parameter logic [BW-1:0]     K2 = KEY2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [BW-1:0] key_byte,
    output logic          open
);
    typedef struct packed {
        lock_e st;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (key_wr) begin
            case (lk_q.st)
                LK_IDLE: lk_d.st = (key_byte == K0) ? LK_ONE  : LK_IDLE;
                LK_ONE:  lk_d.st = (key_byte == K1) ? LK_TWO  : LK_IDLE;
                LK_TWO:  lk_d.st = (key_byte == K2) ? LK_OPEN : LK_IDLE;
                default: lk_d.st = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '{st: LK_IDLE};
        else        lk_q <= lk_d;
    end

    assign open = (lk_q.st == LK_OPEN);
endmodule

// File: rtl/sysclk_selector.sv
module sysclk_selector
    import sysclk_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int SW = SEL_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_hi,
    input  logic          cfg_wr,
    input  logic [SW-1:0] cfg_sel,
    input  logic [DW-1:0] cfg_div,
    input  logic          clr_wr,
    input  logic [NS-1:0] src_stable,
    output logic [SW-1:0] sel,
    output logic          fail,
    output logic [DW-1:0] div_pend,
    output logic          commit
);
    typedef struct packed {
        logic [SW-1:0] sel;
        logic          fail;
        logic [DW-1:0] pend;
    } sel_st_t;

    sel_st_t  s_d, s_q;
    src_map_t tgt;
    logic     tgt_ready;

    always_comb begin
        tgt       = map_code(cfg_sel);
        tgt_ready = tgt.ok && src_stable[tgt.idx];
        s_d       = s_q;
        commit    = 1'b0;
        if (cfg_wr) begin
            s_d.pend = cfg_div;
            if (tgt_ready) begin
                s_d.sel  = cfg_sel;
                s_d.fail = 1'b0;
                commit   = 1'b1;
            end else begin
                s_d.fail = 1'b1;
            end
        end
        if (clr_wr) s_d.fail = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sel: (boot_hi ? {SW{1'b1}} : {SW{1'b0}}), fail: 1'b0, pend: '0};
        else        s_q <= s_d;
    end

    assign sel      = s_q.sel;
    assign fail     = s_q.fail;
    assign div_pend = s_q.pend;
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
    import sysclk_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int SW = SEL_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] src_pulse,
    input  logic [SW-1:0] sel,
    input  logic          restart,
    input  logic [DW-1:0] div_pend,
    output logic          tick,
    output logic [DW-1:0] div_act
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] act;
        logic          tick;
    } div_st_t;

    div_st_t  v_d, v_q;
    src_map_t cur;
    logic [NS-1:0] hit;
    logic     pulse;

    assign cur = map_code(sel);

    for (genvar i = 0; i < NS; i++) begin : g_hit
        assign hit[i] = src_pulse[i] && cur.ok && (int'(cur.idx) == i);
    end

    assign pulse = |hit;

    always_comb begin
        v_d      = v_q;
        v_d.tick = 1'b0;
        if (restart) begin
            v_d.cnt = '0;
        end else if (pulse) begin
            if (v_q.cnt == v_q.act) begin
                v_d.tick = 1'b1;
                v_d.cnt  = '0;
                v_d.act  = div_pend;
            end else begin
                v_d.cnt = v_q.cnt + DW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '{cnt: '0, act: '0, tick: 1'b0};
        else        v_q <= v_d;
    end

    assign tick    = v_q.tick;
    assign div_act = v_q.act;
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
    import sysclk_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int SW = SEL_W,
    parameter int DW = DIV_W,
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_hi,
    input  logic [NS-1:0] src_pulse,
    input  logic [NS-1:0] src_stable,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [BW-1:0] wr_data,
    output logic [SW-1:0] sel_code,
    output logic [DW-1:0] div_active,
    output logic          unlocked,
    output logic          switch_fail,
    output logic          clk_en
);
    localparam int SEL_HI = SEL_LSB + SW - 1;
    localparam int DIV_HI = BW - 1;
    localparam int DIV_LO = BW - DW;

    logic          key_wr, cfg_wr, clr_wr, commit;
    logic [DW-1:0] div_pend;

    assign key_wr = wr_en && (wr_addr == A_KEY);
    assign cfg_wr = wr_en && (wr_addr == A_CFG) && unlocked;
    assign clr_wr = wr_en && (wr_addr == A_CLR) && wr_data[0];

    sysclk_unlock #(.BW(BW)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (wr_data),
        .open     (unlocked)
    );

    sysclk_selector #(.NS(NS), .SW(SW), .DW(DW)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_hi    (boot_hi),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (wr_data[SEL_HI:SEL_LSB]),
        .cfg_div    (wr_data[DIV_HI:DIV_LO]),
        .clr_wr     (clr_wr),
        .src_stable (src_stable),
        .sel        (sel_code),
        .fail       (switch_fail),
        .div_pend   (div_pend),
        .commit     (commit)
    );

    sysclk_divider #(.NS(NS), .SW(SW), .DW(DW)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .sel       (sel_code),
        .restart   (commit),
        .div_pend  (div_pend),
        .tick      (clk_en),
        .div_act   (div_active)
    );
endmodule

// File: rtl/sysclk_switch_checker.sv
module sysclk_switch_checker
    import sysclk_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  src_pulse,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [7:0]  wr_data,
    input logic [2:0]  sel_code,
    input logic [3:0]  div_active,
    input logic        unlocked,
    input logic        switch_fail,
    input logic        clk_en
);
    p_legal_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111}));

    p_strobe_from_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> $past(src_pulse != 5'd0));

    p_div_at_terminal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_active) |-> clk_en);

    p_open_after_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_en && (wr_addr == A_KEY) && (wr_data == KEY2)));

    p_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_KEY) && unlocked) |=> !unlocked);

    p_locked_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_CFG) && !unlocked) |=> ($stable(sel_code) && $stable(switch_fail)));

    p_commit_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code != $past(sel_code)) |-> !switch_fail);

    p_fail_keeps_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(switch_fail) |-> $stable(sel_code));

    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_CLR) && wr_data[0]) |=> !switch_fail);
endmodule

bind sysclk_switch sysclk_switch_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_pulse   (src_pulse),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .sel_code    (sel_code),
    .div_active  (div_active),
    .unlocked    (unlocked),
    .switch_fail (switch_fail),
    .clk_en      (clk_en)
);

// File: tb/sysclk_switch_bench.sv
`timescale 1ns/1ps
module sysclk_switch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_hi = 1'b1;
    logic [4:0] src_pulse = '0;
    logic [4:0] src_stable = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] sel_code;
    logic [3:0] div_active;
    logic       unlocked, switch_fail, clk_en;

    int n_chk = 0;
    int n_fail = 0;
    int tick_no = 0;
    bit done = 0;

    // reference model state
    int m_lock, m_sel, m_fail, m_cnt, m_act, m_pend, m_en;

    always #10 clk = ~clk;

    sysclk_switch u_sysclk_switch (
        .clk(clk), .rst_n(rst_n), .boot_hi(boot_hi),
        .src_pulse(src_pulse), .src_stable(src_stable),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sel_code(sel_code), .div_active(div_active), .unlocked(unlocked),
        .switch_fail(switch_fail), .clk_en(clk_en)
    );

    function automatic int code_to_src(int c);
        case (c)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 3;
            7: return 4;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        int nlock, nsel, nfail, ncnt, nact, npend, nen, t, s, d;
        bit restart;
        if (!rst_n) begin
            m_lock = 0; m_sel = boot_hi ? 7 : 0; m_fail = 0;
            m_cnt = 0; m_act = 0; m_pend = 0; m_en = 0;
        end else begin
            nlock = m_lock; nsel = m_sel; nfail = m_fail;
            ncnt = m_cnt; nact = m_act; npend = m_pend; nen = 0;
            restart = 0;
            d = int'(wr_data);
            if (wr_en) begin
                if (wr_addr == 2'd0) begin
                    if (m_lock == 3) nlock = 0;
                    else if (m_lock == 0 && d == 'h59) nlock = 1;
                    else if (m_lock == 1 && d == 'h16) nlock = 2;
                    else if (m_lock == 2 && d == 'h88) nlock = 3;
                    else nlock = 0;
                end else if (wr_addr == 2'd1 && m_lock == 3) begin
                    npend = d / 16;
                    t = code_to_src(d % 8);
                    if (t >= 0 && src_stable[t]) begin
                        nsel = d % 8; nfail = 0; restart = 1;
                    end else begin
                        nfail = 1;
                    end
                end else if (wr_addr == 2'd2 && wr_data[0]) begin
                    nfail = 0;
                end
            end
            s = code_to_src(m_sel);
            if (restart) ncnt = 0;
            else if (s >= 0 && src_pulse[s]) begin
                if (m_cnt == m_act) begin nen = 1; ncnt = 0; nact = m_pend; end
                else ncnt = m_cnt + 1;
            end
            m_lock = nlock; m_sel = nsel; m_fail = nfail;
            m_cnt = ncnt; m_act = nact; m_pend = npend; m_en = nen;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: wait for edge, compare at negedge, then advance pulses
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk("R2 R8 sel_code vs model", int'(sel_code), m_sel);
        chk("R3 R10 clk_en vs model", int'(clk_en), m_en);
        chk("R4 div_active vs model", int'(div_active), m_act);
        chk("R5 R6 unlocked vs model", int'(unlocked), (m_lock == 3) ? 1 : 0);
        chk("R9 switch_fail vs model", int'(switch_fail), m_fail);
        tick_no++;
        for (int i = 0; i < 5; i++) src_pulse[i] = ((tick_no % (i + 2)) == 0);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic unlock_seq();
        wr(2'd0, 8'h59); wr(2'd0, 8'h16); wr(2'd0, 8'h88);
    endtask

    task automatic do_reset(bit hi);
        boot_hi = hi;
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        cyc();
    endtask

    initial begin
        do_reset(1'b1);
        chk("R1 boot sel 111", int'(sel_code), 7);
        chk("R1 fail clear", int'(switch_fail), 0);
        chk("R1 locked", int'(unlocked), 0);
        chk("R1 div zero", int'(div_active), 0);
        run(20);

        src_stable = 5'b11011;
        // locked configuration write ignored
        wr(2'd1, 8'h20);
        chk("R6 locked cfg keeps sel", int'(sel_code), 7);
        chk("R6 locked cfg keeps fail", int'(switch_fail), 0);

        // broken key sequences
        wr(2'd0, 8'h59); wr(2'd0, 8'h16); wr(2'd0, 8'h77);
        chk("R5 bad third byte", int'(unlocked), 0);
        wr(2'd0, 8'h59); wr(2'd0, 8'h59); wr(2'd0, 8'h16); wr(2'd0, 8'h88);
        chk("R5 repeated first byte restarts", int'(unlocked), 0);
        unlock_seq();
        chk("R5 key opens", int'(unlocked), 1);

        // unstable target (code 010 is bit 2, held low)
        wr(2'd1, 8'h32);
        chk("R8 unstable fail set", int'(switch_fail), 1);
        chk("R8 unstable keeps sel", int'(sel_code), 7);
        run(30);
        wr(2'd2, 8'h00);
        chk("R9 write 0 no effect", int'(switch_fail), 1);
        wr(2'd2, 8'h01);
        chk("R9 write 1 clears", int'(switch_fail), 0);

        // reserved code
        wr(2'd1, 8'h15);
        chk("R8 reserved fail", int'(switch_fail), 1);
        chk("R8 reserved keeps sel", int'(sel_code), 7);
        wr(2'd2, 8'h01);

        // stable commit
        wr(2'd1, 8'h20);
        chk("R7 commit sel 000", int'(sel_code), 0);
        chk("R7 commit fail clear", int'(switch_fail), 0);
        run(40);
        wr(2'd1, 8'h51);
        chk("R7 commit sel 001", int'(sel_code), 1);
        run(60);

        // relock and ignored write
        wr(2'd0, 8'h00);
        chk("R6 relock", int'(unlocked), 0);
        wr(2'd1, 8'h03);
        chk("R6 ignored after relock", int'(sel_code), 1);
        run(20);

        // second boot default
        do_reset(1'b0);
        chk("R1 boot sel 000", int'(sel_code), 0);
        chk("R1 locked after reset", int'(unlocked), 0);
        run(10);
        unlock_seq();
        wr(2'd1, 8'h73);
        chk("R7 commit sel 011", int'(sel_code), 3);
        run(80);
        src_stable = 5'b11111;
        wr(2'd1, 8'hF2);
        chk("R7 commit sel 010", int'(sel_code), 2);
        run(150);
        wr(2'd1, 8'h07);
        chk("R7 commit sel 111", int'(sel_code), 7);
        run(60);
        src_stable = 5'b01111;
        wr(2'd1, 8'h47);
        chk("R8 hf unstable keeps sel", int'(sel_code), 7);
        run(40);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule